// File: doc/BRIEF.md
# DMA Channel Command and Interrupt Register Block

This block is the software-facing control slice of a small multichannel DMA controller. It sits on a simple word-addressed register bus. A single shared command word starts or stops any set of channel engines in one write. For each channel, a four-register window reports the channel's completion events and turns them into an interrupt.

A command write carries a channel bitmap and one selector bit. The selector bit decides whether the selected channels receive a one-cycle start pulse or a one-cycle abort pulse. Each channel engine reports two event levels back to the block: "transfer finished" and "transfer aborted".

The block keeps four views of these events for each channel:
- the live levels;
- a sticky request latched on each rising event and cleared by writing ones;
- a software enable mask;
- a read-only detect word equal to request AND mask.

Each channel's interrupt output is the OR of its detect bits. Several outputs may be wired onto one shared line outside the block, so software reads the detect words to find out which channel fired.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every request and mask bit is 0. All start, abort, interrupt and read-valid outputs are 0, and the read data is 0.
- R2: A write to offset 0x000 with bit 31 = 0 drives `ch_start[n]` high for exactly the one cycle after the write, for each channel n whose bit n in the write data is 1. Bitmap bits at or above the channel count have no effect.
- R3: A write to offset 0x000 with bit 31 = 1 drives `ch_abort[n]` high in the same way, and drives no start pulse. Start and abort are never high together on a channel.
- R4: Channel n's window begins at 0x100 + 0x40·n. Its status word at window offset 0x10 is read-only and shows live levels: bit 1 = finished OR aborted, bit 13 = aborted.
- R5: The request word at window offset 0x14 sets bit 1 on a rising edge of (finished OR aborted). It sets both bit 1 and bit 13 on a rising edge of aborted. A level that stays high does not set the bit again.
- R6: Writing 1 to a request bit clears it, and writing 0 leaves it unchanged. When a clearing write and a setting edge fall in the same cycle, the bit ends up set.
- R7: The mask word at window offset 0x18 stores only bits 1 and 13. All other bits read 0.
- R8: The detect word at window offset 0x1C always reads request AND mask. Writes to it, and to the status word, change nothing.
- R9: `ch_irq[n]` is high exactly when channel n's detect word is non-zero. It follows the register state with no added delay.
- R10: A read request returns its data, with `bus_rd_valid` high, in the next cycle. The command word, unused window offsets and windows of channels beyond the channel count all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | Read data valid, one cycle after bus_rd_en |
| ch_start | output | NCH | One-cycle start pulse per channel |
| ch_abort | output | NCH | One-cycle abort pulse per channel |
| ev_done | input | NCH | Channel finished level from each engine |
| ev_abort | input | NCH | Channel aborted level from each engine |
| ch_irq | output | NCH | Per-channel interrupt |

## Verification
Directed command writes try a start bitmap, an abort bitmap, a bitmap that uses only bits above the channel count, and a bare abort selector. Together they separate the selector decode from the bitmap decode.

Event stimulus covers several cases:
- single finished and aborted rises;
- levels held high across a clear, which tells edge latching from level latching;
- an event rising in the same cycle as its clearing write, which shows the set-over-clear priority;
- all channels firing at once, which shows that each channel keeps its own interrupt.

A final phase of mixed random writes and events is compared every clock against a behavioural model. Reads of unmapped offsets and of absent channel windows confirm the zero read-back.

// File: rtl/dmac_regs_pkg.sv
// Package: shared offsets, bit positions and helper types for the DMA
// channel control register block.
// Assumes: windows are aligned to their stride and the stride is a power of two.
package dmac_regs_pkg;

    localparam int CMD_OFS    = 'h000;
    localparam int WIN_BASE   = 'h100;
    localparam int WIN_STRIDE = 'h040;

    localparam int OFS_RAW  = 'h10;
    localparam int OFS_REQ  = 'h14;
    localparam int OFS_MASK = 'h18;
    localparam int OFS_DET  = 'h1C;

    localparam int BIT_DONE = 1;
    localparam int BIT_ABT  = 13;

    // Compact two-bit event pair: index 0 = finished, index 1 = aborted
    localparam int P_DONE = 0;
    localparam int P_ABT  = 1;
    typedef logic [1:0] evt_pair_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_REQ,
        SEL_MASK,
        SEL_DET
    } reg_sel_e;

    // Spread an event pair onto its register bit positions
    function automatic logic [BIT_ABT:0] pair_to_word(input evt_pair_t p);
        logic [BIT_ABT:0] w;
        w           = '0;
        w[BIT_DONE] = p[P_DONE];
        w[BIT_ABT]  = p[P_ABT];
        return w;
    endfunction

    // Gather the two event bit positions of a register word into a pair
    function automatic evt_pair_t word_to_pair(input logic [BIT_ABT:0] w);
        evt_pair_t p;
        p[P_DONE] = w[BIT_DONE];
        p[P_ABT]  = w[BIT_ABT];
        return p;
    endfunction

endpackage

// File: rtl/dmac_addr_decode.sv
// Module: dmac_addr_decode
// Splits a register byte offset into a command hit, a one-hot channel
// window hit and a register selector within the window.
// Assumes: AW is wide enough to cover every channel window.
module dmac_addr_decode
    import dmac_regs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12
) (
    input  logic [AW-1:0]  addr,
    output logic           hit_cmd,
    output logic [NCH-1:0] win_hit,
    output reg_sel_e       sel
);

    localparam int WIN_SHIFT = $clog2(WIN_STRIDE);
    localparam int FIRST_WIN = WIN_BASE / WIN_STRIDE;
    localparam int PAGE_W    = AW - WIN_SHIFT;

    logic [PAGE_W-1:0]    page;
    logic [WIN_SHIFT-1:0] inner;

    assign page    = addr[AW-1:WIN_SHIFT];
    assign inner   = addr[WIN_SHIFT-1:0];
    assign hit_cmd = (addr == AW'(CMD_OFS));

    // One comparator per channel window
    generate
        for (genvar n = 0; n < NCH; n++) begin : g_win
            assign win_hit[n] = (page == PAGE_W'(FIRST_WIN + n));
        end
    endgenerate

    // Register selector within a window
    always_comb begin
        case (inner)
            WIN_SHIFT'(OFS_RAW):  sel = SEL_RAW;
            WIN_SHIFT'(OFS_REQ):  sel = SEL_REQ;
            WIN_SHIFT'(OFS_MASK): sel = SEL_MASK;
            WIN_SHIFT'(OFS_DET):  sel = SEL_DET;
            default:              sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/dmac_cmd_decode.sv
// Module: dmac_cmd_decode
// Turns a write of the shared command word into registered one-cycle start
// or abort pulses for the channels selected by the bitmap.
// Assumes: DW > NCH, and the top bit of the word is the abort selector.
module dmac_cmd_decode #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [DW-1:0]  cmd_word,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] abort_o
);

    localparam int SEL_BIT = DW - 1;

    logic [NCH-1:0] bitmap;
    logic           is_abort;

    assign bitmap   = cmd_word[NCH-1:0];
    assign is_abort = cmd_word[SEL_BIT];

    // Pulse registers: high for one cycle after a command write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
            abort_o <= '0;
        end else begin
            start_o <= (cmd_wr && !is_abort) ? bitmap : '0;
            abort_o <= (cmd_wr &&  is_abort) ? bitmap : '0;
        end
    end

endmodule

// File: rtl/dmac_irq_chan.sv
// Module: dmac_irq_chan
// One channel's interrupt state: the live event view, edge-latched requests
// cleared by writing ones, the enable mask, the detect word and the
// interrupt output.
// Assumes: event levels are synchronous to clk. An aborted rise also counts
// as a finished rise.
module dmac_irq_chan
    import dmac_regs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ev_done,
    input  logic      ev_abort,
    input  logic      req_wr,
    input  logic      mask_wr,
    input  evt_pair_t wr_pair,
    output evt_pair_t raw_o,
    output evt_pair_t req_o,
    output evt_pair_t mask_o,
    output evt_pair_t det_o,
    output logic      irq_o
);

    evt_pair_t prev_q;
    evt_pair_t req_q;
    evt_pair_t mask_q;
    evt_pair_t rise;
    evt_pair_t set_v;
    evt_pair_t clr_v;

    // Live view: finished bit also reflects an abort
    assign raw_o[P_DONE] = ev_done | ev_abort;
    assign raw_o[P_ABT]  = ev_abort;

    // Rising edges; an abort rise sets both request bits
    assign rise          = raw_o & ~prev_q;
    assign set_v[P_DONE] = rise[P_DONE] | rise[P_ABT];
    assign set_v[P_ABT]  = rise[P_ABT];
    assign clr_v         = req_wr ? wr_pair : 2'b00;

    // Previous event levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= raw_o;
    end

    // Request latch: a set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~clr_v) | set_v;
    end

    // Enable mask: plain storage of the two event bits
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_pair;
    end

    assign req_o  = req_q;
    assign mask_o = mask_q;
    assign det_o  = req_q & mask_q;
    assign irq_o  = |det_o;

endmodule

// File: rtl/dmac_ctl_regs.sv
// Module: dmac_ctl_regs (top)
// Register front end of a multichannel DMA controller: shared command word,
// per-channel interrupt windows, and registered read data.
// Assumes: NCH is 1 to 8, DW is 32, and accesses are word aligned.
module dmac_ctl_regs
    import dmac_regs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr_en,
    input  logic           bus_rd_en,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_rd_valid,
    output logic [NCH-1:0] ch_start,
    output logic [NCH-1:0] ch_abort,
    input  logic [NCH-1:0] ev_done,
    input  logic [NCH-1:0] ev_abort,
    output logic [NCH-1:0] ch_irq
);

    localparam int FLD_W = BIT_ABT + 1;

    logic           hit_cmd;
    logic [NCH-1:0] win_hit;
    reg_sel_e       sel;
    evt_pair_t      wr_pair;
    evt_pair_t      raw_a  [NCH];
    evt_pair_t      req_a  [NCH];
    evt_pair_t      mask_a [NCH];
    evt_pair_t      det_a  [NCH];
    logic [DW-1:0]  rd_word;

    assign wr_pair = word_to_pair(bus_wdata[FLD_W-1:0]);

    dmac_addr_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr    (bus_addr),
        .hit_cmd (hit_cmd),
        .win_hit (win_hit),
        .sel     (sel)
    );

    dmac_cmd_decode #(.NCH(NCH), .DW(DW)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (bus_wr_en && hit_cmd),
        .cmd_word (bus_wdata),
        .start_o  (ch_start),
        .abort_o  (ch_abort)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            dmac_irq_chan u_irq (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev_done  (ev_done[n]),
                .ev_abort (ev_abort[n]),
                .req_wr   (bus_wr_en && win_hit[n] && (sel == SEL_REQ)),
                .mask_wr  (bus_wr_en && win_hit[n] && (sel == SEL_MASK)),
                .wr_pair  (wr_pair),
                .raw_o    (raw_a[n]),
                .req_o    (req_a[n]),
                .mask_o   (mask_a[n]),
                .det_o    (det_a[n]),
                .irq_o    (ch_irq[n])
            );
        end
    endgenerate

    // Read multiplexer: OR of the selected window's register, zero elsewhere
    always_comb begin
        rd_word = '0;
        for (int n = 0; n < NCH; n++) begin
            if (win_hit[n]) begin
                case (sel)
                    SEL_RAW:  rd_word = rd_word | DW'(pair_to_word(raw_a[n]));
                    SEL_REQ:  rd_word = rd_word | DW'(pair_to_word(req_a[n]));
                    SEL_MASK: rd_word = rd_word | DW'(pair_to_word(mask_a[n]));
                    SEL_DET:  rd_word = rd_word | DW'(pair_to_word(det_a[n]));
                    default:  rd_word = rd_word;
                endcase
            end
        end
    end

    // Registered read return, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata    <= '0;
            bus_rd_valid <= 1'b0;
        end else begin
            bus_rd_valid <= bus_rd_en;
            bus_rdata    <= bus_rd_en ? rd_word : '0;
        end
    end

endmodule

// File: rtl/dmac_ctl_regs_chk.sv
// Module: dmac_ctl_regs_chk
// Port-level temporal checks for dmac_ctl_regs, attached by bind.
// Assumes: sampled on the rising clock edge, with checks disabled in reset.
module dmac_ctl_regs_chk #(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr_en,
    input logic           bus_rd_en,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           bus_rd_valid,
    input logic [NCH-1:0] ch_start,
    input logic [NCH-1:0] ch_abort,
    input logic [NCH-1:0] ev_done,
    input logic [NCH-1:0] ev_abort,
    input logic [NCH-1:0] ch_irq
);

    // R2: a start pulse follows a start-type command write
    p_start_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> $past(bus_wr_en && bus_addr == '0 && !bus_wdata[DW-1]));

    // R2: without a new write a pulse lasts one cycle
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_start != '0) && !bus_wr_en) |=> (ch_start == '0));

    // R3: an abort pulse follows an abort-type command write
    p_abort_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_abort != '0) |-> $past(bus_wr_en && bus_addr == '0 && bus_wdata[DW-1]));

    // R3: never start and abort on the same channel
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_start & ch_abort) == '0));

    // R10: read data valid exactly after a read request
    p_rvalid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_valid |-> $past(bus_rd_en));

    p_rvalid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_rd_valid);

    // R10: the command word reads back as zero
    p_cmd_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == '0) |=> (bus_rdata == '0));

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_irq
            // R9: an interrupt rises only after an event or a mask write
            p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_irq[n]) |-> $past(bus_wr_en || ev_done[n] || ev_abort[n]));

            // R6: an interrupt falls only after a register write
            p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ch_irq[n]) |-> $past(bus_wr_en));
        end
    endgenerate

endmodule

bind dmac_ctl_regs dmac_ctl_regs_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rd_valid (bus_rd_valid),
    .ch_start     (ch_start),
    .ch_abort     (ch_abort),
    .ev_done      (ev_done),
    .ev_abort     (ev_abort),
    .ch_irq       (ch_irq)
);

// File: tb/dmac_ctl_regs_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed
// read-back checks with fixed expected values.
module dmac_ctl_regs_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 12;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0;
    logic [DW-1:0]  rdata;
    logic           rvalid;
    logic [NCH-1:0] start_p, abort_p, irq;
    logic [NCH-1:0] evd = '0;
    logic [NCH-1:0] eva = '0;

    always #10 clk = ~clk;

    dmac_ctl_regs #(.NCH(NCH), .AW(AW), .DW(DW)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_wr_en (wr_en), .bus_rd_en (rd_en), .bus_addr (addr),
        .bus_wdata (wdata), .bus_rdata (rdata), .bus_rd_valid (rvalid),
        .ch_start (start_p), .ch_abort (abort_p),
        .ev_done (evd), .ev_abort (eva), .ch_irq (irq)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int    m_req [NCH];
    int    m_en  [NCH];
    int    m_pd  [NCH];
    int    m_pa  [NCH];
    int    m_start = 0, m_abort = 0, m_rdata = 0, m_rvalid = 0;
    string m_tag = "R10";
    bit    live = 0;

    function automatic int win_of(input int a);
        if (a >= 'h100 && a < 'h100 + 'h40 * NCH) return (a - 'h100) / 'h40;
        return -1;
    endfunction

    function automatic string tag_of(input int a);
        int c = win_of(a);
        if (c < 0) return "R10";
        case ((a - 'h100) % 'h40)
            'h10: return "R4";
            'h14: return "R5";
            'h18: return "R7";
            'h1C: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic int model_read(input int a);
        int c = win_of(a);
        if (c < 0) return 0;
        case ((a - 'h100) % 'h40)
            'h10: return ((evd[c] | eva[c]) ? 'h2 : 0) | (eva[c] ? 'h2000 : 0);
            'h14: return m_req[c];
            'h18: return m_en[c];
            'h1C: return m_req[c] & m_en[c];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                m_req[n] = 0; m_en[n] = 0; m_pd[n] = 0; m_pa[n] = 0;
            end
            m_start = 0; m_abort = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            m_rvalid = rd_en;
            m_rdata  = rd_en ? model_read(int'(addr)) : 0;
            m_tag    = tag_of(int'(addr));
            m_start  = 0;
            m_abort  = 0;
            if (wr_en && addr == 0) begin
                for (int n = 0; n < NCH; n++) begin
                    if (wdata[n]) begin
                        if (wdata[31]) m_abort |= (1 << n);
                        else           m_start |= (1 << n);
                    end
                end
            end
            for (int n = 0; n < NCH; n++) begin
                int lvl, setv;
                lvl  = (evd[n] | eva[n]) ? 1 : 0;
                setv = 0;
                if (lvl == 1 && m_pd[n] == 0) setv |= 'h2;
                if (eva[n] && m_pa[n] == 0)   setv |= 'h2002;
                if (wr_en && int'(addr) == 'h114 + 'h40 * n)
                    m_req[n] &= ~(int'(wdata) & 'h2002);
                m_req[n] |= setv;
                if (wr_en && int'(addr) == 'h118 + 'h40 * n)
                    m_en[n] = int'(wdata) & 'h2002;
                m_pd[n] = lvl;
                m_pa[n] = eva[n] ? 1 : 0;
            end
        end
        live = 1;
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !done_flag) begin
            for (int n = 0; n < NCH; n++)
                check(irq[n] == ((m_req[n] & m_en[n]) != 0), "R9", "irq",
                      irq[n], (m_req[n] & m_en[n]) != 0);
            check(int'(start_p) == m_start, "R2", "start pulses", start_p, m_start);
            check(int'(abort_p) == m_abort, "R3", "abort pulses", abort_p, m_abort);
            check(int'(rvalid) == m_rvalid, "R10", "read valid", rvalid, m_rvalid);
            if (m_rvalid != 0)
                check(int'(rdata) == m_rdata, m_tag, "read data", rdata, m_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(rvalid && int'(rdata) == exp, tag, $sformatf("read %0h", a), rdata, exp);
    endtask

    task automatic cmd_chk(input int d, input int exp_s, input int exp_a, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = '0; wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        check(int'(start_p) == exp_s && int'(abort_p) == exp_a, tag, "command pulse",
              {start_p, abort_p}, {exp_s[NCH-1:0], exp_a[NCH-1:0]});
        @(negedge clk);
        check(start_p == '0 && abort_p == '0, tag, "pulse width one cycle",
              {start_p, abort_p}, 0);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in the registers
        check(start_p == '0 && abort_p == '0 && irq == '0 && rvalid == 1'b0 && rdata == '0,
              "R1", "outputs after reset", {start_p, abort_p, irq}, 0);
        bus_rd_chk('h114, 0, "R1");
        bus_rd_chk('h1D8, 0, "R1");

        // Command decode
        cmd_chk('h0000_0005, 'h5, 'h0, "R2");
        cmd_chk('h8000_000A, 'h0, 'hA, "R3");
        cmd_chk('h0000_00F0, 'h0, 'h0, "R2");
        cmd_chk('h8000_0000, 'h0, 'h0, "R3");

        // Finished event on channel 0
        @(negedge clk); evd[0] = 1'b1;
        @(negedge clk);
        bus_rd_chk('h114, 'h2, "R5");
        bus_rd_chk('h110, 'h2, "R4");
        bus_rd_chk('h11C, 'h0, "R8");
        check(irq[0] == 1'b0, "R9", "masked irq", irq[0], 0);
        bus_wr('h118, 'hFFFF_FFFF);
        bus_rd_chk('h118, 'h2002, "R7");
        bus_rd_chk('h11C, 'h2, "R8");
        check(irq[0] == 1'b1, "R9", "enabled irq", irq[0], 1);
        bus_wr('h114, 'h0);
        bus_rd_chk('h114, 'h2, "R6");
        bus_wr('h114, 'h2);
        bus_rd_chk('h114, 'h0, "R6");
        check(irq[0] == 1'b0, "R6", "irq after clear with level held", irq[0], 0);
        @(negedge clk); evd[0] = 1'b0;

        // Abort event on channel 1
        @(negedge clk); eva[1] = 1'b1;
        @(negedge clk);
        bus_rd_chk('h154, 'h2002, "R5");
        bus_wr('h158, 'h2000);
        bus_rd_chk('h15C, 'h2000, "R8");
        check(irq[1] == 1'b1, "R9", "abort irq", irq[1], 1);
        bus_wr('h150, 'hFFFF_FFFF);
        bus_rd_chk('h150, 'h2002, "R4");
        bus_wr('h15C, 'hFFFF_FFFF);
        bus_rd_chk('h154, 'h2002, "R8");
        @(negedge clk); eva[1] = 1'b0;

        // Set and clear in the same cycle on channel 2
        @(negedge clk); evd[2] = 1'b1;
        @(negedge clk); evd[2] = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; addr = AW'('h194); wdata = 'h2; evd[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        bus_rd_chk('h194, 'h2, "R6");

        // Unmapped and command read-back
        bus_rd_chk('h000, 0, "R10");
        bus_rd_chk('h004, 0, "R10");
        bus_rd_chk('h100, 0, "R10");
        bus_rd_chk('h120, 0, "R10");
        bus_rd_chk('h210, 0, "R10");

        // All channels together
        evd = '0; eva = '0;
        for (int n = 0; n < NCH; n++) bus_wr('h114 + 'h40 * n, 'h2002);
        for (int n = 0; n < NCH; n++) bus_wr('h118 + 'h40 * n, 'h2);
        @(negedge clk); evd = '1;
        @(negedge clk);
        check(irq == '1, "R9", "all channels irq", irq, 4'hF);
        bus_wr('h1D4, 'h2);
        check(irq == 4'h7, "R9", "one channel cleared", irq, 4'h7);
        evd = '0;

        // Mixed random phase, compared by the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            evd   = NCH'($urandom);
            eva   = NCH'($urandom) & NCH'($urandom);
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 2) == 0;
            case ($urandom % 6)
                0: addr = '0;
                1: addr = AW'('h110 + 'h40 * ($urandom % NCH));
                2: addr = AW'('h114 + 'h40 * ($urandom % NCH));
                3: addr = AW'('h118 + 'h40 * ($urandom % NCH));
                4: addr = AW'('h11C + 'h40 * ($urandom % NCH));
                default: addr = AW'($urandom % 'h400) & ~AW'(3);
            endcase
            wdata = $urandom;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule